// File: doc/BRIEF.md
# Guest Interrupt Virtualization Controller

This block decides what happens to interrupts while a guest context runs on the core. It takes four kinds of input. The first is an external interrupt request with its vector. The second is the guest's own writes to its interrupt-enable flag. The third is two control bits owned by the hypervisor: one turns external interrupts into exits, the other asks for an exit when the guest's interrupt window opens. The fourth is a pair of pending registers that the hypervisor loads: a virtual interrupt that waits for the guest to unmask, and an event that is injected when guest entry completes.

For each cycle the block either raises an exit toward the hypervisor, tagged with a reason code, or hands an interrupt to the guest, tagged with the kind of delivery, or does nothing. Exits leave on a valid/ready stream. Once `exit_valid` is high, the reason stays frozen until `exit_ready` is sampled high on a rising edge. A new exit is loaded only when the stream is empty or is being drained in that same cycle. Interrupt sources are level inputs and are not buffered, so a source stalled by back-pressure is simply seen again later. Deliveries are single-cycle pulses with no back-pressure. The guest consumes them when they appear.

All decisions are registered. An output reflects the inputs and the state of the previous cycle.

Top module: `gi_virt_ctrl`

## Requirements
- R1: While `ctl_extint_exit` is 1 and a guest is active, an asserted `ext_irq` raises an exit with reason code 1 on the next cycle, and it is never delivered directly to the guest.
- R2: While `ctl_extint_exit` is 1, `phys_masked` stays 0 whatever the guest flag holds, and guest writes to the flag still update `guest_ie` but raise no exit.
- R3: While `ctl_window_exit` is 1 and `guest_ie` is 1, an exit with reason code 2 is raised on the next cycle. A write that sets the flag leads to the exit one cycle after the flag itself changes.
- R4: A registered virtual interrupt is delivered with kind code 3 and vector `VIRT_VEC` only when `guest_ie` was 1 in the deciding cycle. The delivery clears the pending register, so it is delivered once.
- R5: An armed injection is delivered with kind code 1 and its armed vector in the cycle after `guest_entry`, whatever the mask state. `inject_ack` pulses in that same cycle, and a later entry delivers nothing.
- R6: When an external-interrupt exit and an interrupt-window exit qualify together, the reason code is 1.
- R7: While `exit_valid` is 1 and `exit_ready` is 0, `exit_valid` and `exit_reason` hold their values.
- R8: No direct or virtual delivery occurs while an exit is outstanding or is being requested in the deciding cycle.
- R9: With `ctl_extint_exit` at 0, an external interrupt is delivered directly with kind code 2 and its vector when `guest_ie` is 1. When `guest_ie` is 0 it is held off and `phys_masked` reads 1.
- R10: After reset, `exit_valid`, `deliver_valid`, `inject_ack` and `guest_ie` are 0 and `exit_reason` is 0.
- R11: When several deliveries qualify together, injection wins over direct external delivery, and direct external delivery wins over virtual delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guest_active | input | 1 | A guest context is running |
| guest_entry | input | 1 | Guest entry completes this cycle |
| ext_irq | input | 1 | External interrupt request, level |
| ext_vec | input | VEC_W | Vector of the external interrupt |
| ctl_extint_exit | input | 1 | Hypervisor control: external interrupts cause exits |
| ctl_window_exit | input | 1 | Hypervisor control: exit when guest unmasks |
| ie_wr | input | 1 | Guest writes its interrupt-enable flag |
| ie_wdata | input | 1 | Value written to the flag |
| virq_set | input | 1 | Hypervisor registers a virtual interrupt |
| inject_arm | input | 1 | Hypervisor arms an entry injection |
| inject_vec | input | VEC_W | Vector of the armed injection |
| exit_ready | input | 1 | Hypervisor accepts the exit |
| exit_valid | output | 1 | Exit request outstanding |
| exit_reason | output | 2 | 1 external interrupt, 2 interrupt window, 0 none |
| deliver_valid | output | 1 | One-cycle delivery to the guest |
| deliver_kind | output | 2 | 1 injection, 2 direct external, 3 virtual |
| deliver_vec | output | VEC_W | Delivered vector |
| inject_ack | output | 1 | Armed injection consumed |
| guest_ie | output | 1 | Current guest interrupt-enable flag |
| phys_masked | output | 1 | Physical interrupts are masked by the guest |

## Verification
A guest flag register that went wrong would show in two places. `phys_masked` would change at once, and window exits or held-off deliveries would change one cycle later. A pending virtual interrupt or injection that failed to clear would show up as a second delivery on the next qualifying cycle. A wrong exit arbiter would either change `exit_reason` while the stream is stalled, or allow a delivery in the same cycle that an exit is first requested. Both of these are visible on the cycle right after the stimulus.

// File: rtl/gi_pkg.sv
package gi_pkg;
  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_EXTINT = 2'd1,
    RSN_WINDOW = 2'd2
  } exit_rsn_e;

  typedef enum logic [1:0] {
    DLV_NONE    = 2'd0,
    DLV_INJECT  = 2'd1,
    DLV_EXTERN  = 2'd2,
    DLV_VIRTUAL = 2'd3
  } dlv_kind_e;
endpackage

// File: rtl/gi_mask_ctrl.sv
module gi_mask_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic guest_active,
  input  logic ie_wr,
  input  logic ie_wdata,
  input  logic ctl_extint_exit,
  output logic ie_q,
  output logic phys_masked
);
  // guest-visible flag; updated only by writes from a running guest
  always_ff @(posedge clk) begin
    if (!rst_n)                     ie_q <= 1'b0;
    else if (guest_active && ie_wr) ie_q <= ie_wdata;
  end

  // the guest loses mask authority when external interrupts are trapped
  always_comb phys_masked = guest_active && !ctl_extint_exit && !ie_q;
endmodule

// File: rtl/gi_exit_arb.sv
module gi_exit_arb
  import gi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       guest_active,
  input  logic       ext_irq,
  input  logic       ctl_extint_exit,
  input  logic       ctl_window_exit,
  input  logic       ie_q,
  input  logic       exit_ready,
  output logic       exit_valid,
  output exit_rsn_e  exit_reason,
  output logic       exit_block
);
  logic      ext_hit, win_hit, want;
  exit_rsn_e rsn_nxt;
  logic      load;

  always_comb begin
    ext_hit = guest_active && ctl_extint_exit && ext_irq;
    win_hit = guest_active && ctl_window_exit && ie_q;
    want    = ext_hit || win_hit;
    // external interrupt outranks the window
    if (ext_hit)      rsn_nxt = RSN_EXTINT;
    else if (win_hit) rsn_nxt = RSN_WINDOW;
    else              rsn_nxt = RSN_NONE;
    load       = !exit_valid || exit_ready;
    exit_block = exit_valid || want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exit_valid  <= 1'b0;
      exit_reason <= RSN_NONE;
    end else if (load) begin
      exit_valid  <= want;
      exit_reason <= rsn_nxt;
    end
  end
endmodule

// File: rtl/gi_deliver.sv
module gi_deliver
  import gi_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VIRT_VEC = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             guest_active,
  input  logic             guest_entry,
  input  logic             ext_irq,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             ctl_extint_exit,
  input  logic             ie_q,
  input  logic             exit_block,
  input  logic             virq_set,
  input  logic             inject_arm,
  input  logic [VEC_W-1:0] inject_vec,
  output logic             deliver_valid,
  output dlv_kind_e        deliver_kind,
  output logic [VEC_W-1:0] deliver_vec,
  output logic             inject_ack
);
  logic             inj_pend;
  logic [VEC_W-1:0] inj_vec_q;
  logic             virq_pend;
  logic             fire_inj, fire_ext, fire_virt, open_gate;
  dlv_kind_e        kind_nxt;
  logic [VEC_W-1:0] vec_nxt;

  always_comb begin
    open_gate = guest_active && !exit_block && ie_q;
    fire_inj  = guest_entry && inj_pend;
    fire_ext  = !fire_inj && open_gate && ext_irq && !ctl_extint_exit;
    fire_virt = !fire_inj && !fire_ext && open_gate && virq_pend;
    kind_nxt  = DLV_NONE;
    vec_nxt   = '0;
    if (fire_inj) begin
      kind_nxt = DLV_INJECT;
      vec_nxt  = inj_vec_q;
    end else if (fire_ext) begin
      kind_nxt = DLV_EXTERN;
      vec_nxt  = ext_vec;
    end else if (fire_virt) begin
      kind_nxt = DLV_VIRTUAL;
      vec_nxt  = VIRT_VEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_pend      <= 1'b0;
      inj_vec_q     <= '0;
      virq_pend     <= 1'b0;
      deliver_valid <= 1'b0;
      deliver_kind  <= DLV_NONE;
      deliver_vec   <= '0;
      inject_ack    <= 1'b0;
    end else begin
      deliver_valid <= fire_inj || fire_ext || fire_virt;
      deliver_kind  <= kind_nxt;
      deliver_vec   <= vec_nxt;
      inject_ack    <= fire_inj;
      if (inject_arm) begin
        inj_pend  <= 1'b1;
        inj_vec_q <= inject_vec;
      end else if (fire_inj) begin
        inj_pend  <= 1'b0;
      end
      if (virq_set)       virq_pend <= 1'b1;
      else if (fire_virt) virq_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/gi_virt_ctrl.sv
module gi_virt_ctrl
  import gi_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VIRT_VEC = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             guest_active,
  input  logic             guest_entry,
  input  logic             ext_irq,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             ctl_extint_exit,
  input  logic             ctl_window_exit,
  input  logic             ie_wr,
  input  logic             ie_wdata,
  input  logic             virq_set,
  input  logic             inject_arm,
  input  logic [VEC_W-1:0] inject_vec,
  input  logic             exit_ready,
  output logic             exit_valid,
  output logic [1:0]       exit_reason,
  output logic             deliver_valid,
  output logic [1:0]       deliver_kind,
  output logic [VEC_W-1:0] deliver_vec,
  output logic             inject_ack,
  output logic             guest_ie,
  output logic             phys_masked
);
  logic      ie_q, exit_block;
  exit_rsn_e rsn;
  dlv_kind_e kind;

  gi_mask_ctrl u_mask (
    .clk(clk), .rst_n(rst_n), .guest_active(guest_active),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ctl_extint_exit(ctl_extint_exit),
    .ie_q(ie_q), .phys_masked(phys_masked)
  );

  gi_exit_arb u_exit (
    .clk(clk), .rst_n(rst_n), .guest_active(guest_active), .ext_irq(ext_irq),
    .ctl_extint_exit(ctl_extint_exit), .ctl_window_exit(ctl_window_exit),
    .ie_q(ie_q), .exit_ready(exit_ready), .exit_valid(exit_valid),
    .exit_reason(rsn), .exit_block(exit_block)
  );

  gi_deliver #(.VEC_W(VEC_W), .VIRT_VEC(VIRT_VEC)) u_dlv (
    .clk(clk), .rst_n(rst_n), .guest_active(guest_active),
    .guest_entry(guest_entry), .ext_irq(ext_irq), .ext_vec(ext_vec),
    .ctl_extint_exit(ctl_extint_exit), .ie_q(ie_q), .exit_block(exit_block),
    .virq_set(virq_set), .inject_arm(inject_arm), .inject_vec(inject_vec),
    .deliver_valid(deliver_valid), .deliver_kind(kind),
    .deliver_vec(deliver_vec), .inject_ack(inject_ack)
  );

  always_comb begin
    exit_reason  = rsn;
    deliver_kind = kind;
    guest_ie     = ie_q;
  end
endmodule

// File: rtl/gi_virt_ctrl_chk.sv
module gi_virt_ctrl_chk #(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             guest_active,
  input logic             guest_entry,
  input logic             ext_irq,
  input logic             ctl_extint_exit,
  input logic             ctl_window_exit,
  input logic             ie_wr,
  input logic             exit_ready,
  input logic             exit_valid,
  input logic [1:0]       exit_reason,
  input logic             deliver_valid,
  input logic [1:0]       deliver_kind,
  input logic             inject_ack,
  input logic             guest_ie,
  input logic             phys_masked
);
  p_ext_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    guest_active && ctl_extint_exit && ext_irq && (!exit_valid || exit_ready)
    |=> exit_valid && exit_reason == 2'd1);

  p_no_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_extint_exit |=> !(deliver_valid && deliver_kind == 2'd2));

  p_no_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_extint_exit |-> !phys_masked);

  p_write_no_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_extint_exit && !ext_irq && !ctl_window_exit && ie_wr && (!exit_valid || exit_ready)
    |=> !exit_valid);

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guest_active && ctl_window_exit && guest_ie && !(ctl_extint_exit && ext_irq)
    && (!exit_valid || exit_ready) |=> exit_valid && exit_reason == 2'd2);

  p_virt_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_valid && deliver_kind == 2'd3 |-> $past(guest_ie));

  p_inj_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inject_ack |-> deliver_valid && deliver_kind == 2'd1 && $past(guest_entry));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    guest_active && ctl_extint_exit && ext_irq && ctl_window_exit && guest_ie
    && (!exit_valid || exit_ready) |=> exit_reason == 2'd1);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid && !exit_ready |=> exit_valid && $stable(exit_reason));

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid && !guest_entry |=> !deliver_valid);
endmodule

bind gi_virt_ctrl gi_virt_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .guest_active(guest_active), .guest_entry(guest_entry),
  .ext_irq(ext_irq), .ctl_extint_exit(ctl_extint_exit),
  .ctl_window_exit(ctl_window_exit), .ie_wr(ie_wr), .exit_ready(exit_ready),
  .exit_valid(exit_valid), .exit_reason(exit_reason), .deliver_valid(deliver_valid),
  .deliver_kind(deliver_kind), .inject_ack(inject_ack), .guest_ie(guest_ie),
  .phys_masked(phys_masked)
);

// File: tb/tb_gi_virt_ctrl.sv
`timescale 1ns/1ps
module tb_gi_virt_ctrl;
  localparam int VW = 8;
  localparam logic [VW-1:0] VV = 8'hF0;

  logic clk = 1'b0;
  logic rst_n;
  logic guest_active, guest_entry, ext_irq, ctl_ext, ctl_win;
  logic ie_wr, ie_wdata, virq_set, inject_arm, exit_ready;
  logic [VW-1:0] ext_vec, inject_vec;
  logic exit_valid, deliver_valid, inject_ack, guest_ie, phys_masked;
  logic [1:0] exit_reason, deliver_kind;
  logic [VW-1:0] deliver_vec;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gi_virt_ctrl #(.VEC_W(VW), .VIRT_VEC(VV)) dut (
    .clk(clk), .rst_n(rst_n), .guest_active(guest_active), .guest_entry(guest_entry),
    .ext_irq(ext_irq), .ext_vec(ext_vec), .ctl_extint_exit(ctl_ext),
    .ctl_window_exit(ctl_win), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .virq_set(virq_set), .inject_arm(inject_arm), .inject_vec(inject_vec),
    .exit_ready(exit_ready), .exit_valid(exit_valid), .exit_reason(exit_reason),
    .deliver_valid(deliver_valid), .deliver_kind(deliver_kind),
    .deliver_vec(deliver_vec), .inject_ack(inject_ack), .guest_ie(guest_ie),
    .phys_masked(phys_masked)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    guest_entry = 0; ext_irq = 0; ctl_ext = 0; ctl_win = 0; ie_wr = 0; ie_wdata = 0;
    virq_set = 0; inject_arm = 0; exit_ready = 1; ext_vec = '0; inject_vec = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    guest_active = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
    guest_active = 1;
  endtask

  task automatic write_ie(input logic v);
    ie_wr = 1; ie_wdata = v;
    step();
    ie_wr = 0;
  endtask

  task automatic t_reset();
    idle_inputs(); guest_active = 0; rst_n = 0;
    step(); step();
    check("R10 exit_valid", exit_valid, 0);
    check("R10 exit_reason", exit_reason, 0);
    check("R10 deliver_valid", deliver_valid, 0);
    check("R10 inject_ack", inject_ack, 0);
    check("R10 guest_ie", guest_ie, 0);
    rst_n = 1;
  endtask

  task automatic t_ext_exit();
    do_reset();
    write_ie(1);
    ctl_ext = 1; ext_irq = 1; ext_vec = 8'h21;
    step();
    check("R1 exit_valid", exit_valid, 1);
    check("R1 exit_reason", exit_reason, 1);
    check("R1 no direct delivery", deliver_valid, 0);
    ext_irq = 0;
    step();
    check("R1 exit drops", exit_valid, 0);
    check("R1 still no delivery", deliver_valid, 0);
  endtask

  task automatic t_nomask();
    do_reset();
    ctl_ext = 1;
    #0;
    check("R2 phys_masked with ie=0", phys_masked, 0);
    write_ie(0);
    check("R2 no exit on write 0", exit_valid, 0);
    check("R2 flag stays 0", guest_ie, 0);
    write_ie(1);
    check("R2 no exit on write 1", exit_valid, 0);
    check("R2 flag updated", guest_ie, 1);
    write_ie(0);
    check("R2 phys_masked after write 0", phys_masked, 0);
    ctl_ext = 0;
    #0;
    check("R9 phys_masked with control off", phys_masked, 1);
  endtask

  task automatic t_window();
    do_reset();
    ctl_win = 1;
    step();
    check("R3 no exit while masked", exit_valid, 0);
    write_ie(1);
    check("R3 exit not yet on flag edge", exit_valid, 0);
    step();
    check("R3 window exit", exit_valid, 1);
    check("R3 window reason", exit_reason, 2);
    ctl_win = 0;
    step();
    check("R3 exit clears", exit_valid, 0);
  endtask

  task automatic t_prio();
    do_reset();
    write_ie(1);
    ctl_win = 1; ctl_ext = 1; ext_irq = 1;
    step();
    check("R6 exit_valid", exit_valid, 1);
    check("R6 reason external", exit_reason, 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    write_ie(1);
    exit_ready = 0; ctl_ext = 1; ext_irq = 1;
    step();
    check("R7 first exit", exit_reason, 1);
    ext_irq = 0; ctl_ext = 0; ctl_win = 1;
    step();
    check("R7 held valid", exit_valid, 1);
    check("R7 held reason", exit_reason, 1);
    step();
    check("R7 still held", exit_reason, 1);
    exit_ready = 1;
    step();
    check("R7 next exit loaded", exit_valid, 1);
    check("R7 next reason window", exit_reason, 2);
    ctl_win = 0;
    step();
    check("R7 drained", exit_valid, 0);
  endtask

  task automatic t_direct();
    do_reset();
    write_ie(1);
    ext_irq = 1; ext_vec = 8'h21;
    step();
    check("R9 direct valid", deliver_valid, 1);
    check("R9 direct kind", deliver_kind, 2);
    check("R9 direct vec", deliver_vec, 8'h21);
    ext_irq = 0;
    write_ie(0);
    ext_irq = 1;
    step();
    check("R9 held off when masked", deliver_valid, 0);
    check("R9 phys_masked", phys_masked, 1);
  endtask

  task automatic t_virt();
    do_reset();
    virq_set = 1;
    step();
    virq_set = 0;
    step();
    check("R4 no delivery while masked", deliver_valid, 0);
    write_ie(1);
    check("R4 not on flag edge", deliver_valid, 0);
    step();
    check("R4 virtual valid", deliver_valid, 1);
    check("R4 virtual kind", deliver_kind, 3);
    check("R4 virtual vec", deliver_vec, VV);
    step();
    check("R4 delivered once", deliver_valid, 0);
  endtask

  task automatic t_inject();
    do_reset();
    inject_arm = 1; inject_vec = 8'h40;
    step();
    inject_arm = 0;
    step();
    check("R5 idle before entry", deliver_valid, 0);
    guest_entry = 1;
    step();
    check("R5 inject valid while masked", deliver_valid, 1);
    check("R5 inject kind", deliver_kind, 1);
    check("R5 inject vec", deliver_vec, 8'h40);
    check("R5 ack", inject_ack, 1);
    step();
    check("R5 second entry no delivery", deliver_valid, 0);
    check("R5 ack gone", inject_ack, 0);
  endtask

  task automatic t_block();
    do_reset();
    write_ie(1);
    ctl_win = 1; virq_set = 1;
    step();
    virq_set = 0; exit_ready = 0;
    check("R8 exit raised", exit_valid, 1);
    check("R8 no delivery on request", deliver_valid, 0);
    step();
    check("R8 no delivery while outstanding", deliver_valid, 0);
    ctl_win = 0; exit_ready = 1;
    step();
    check("R8 exit drained", exit_valid, 0);
    check("R8 still blocked on drain", deliver_valid, 0);
    step();
    check("R8 virtual after drain", deliver_valid, 1);
    check("R8 virtual kind", deliver_kind, 3);
  endtask

  task automatic t_order();
    do_reset();
    virq_set = 1; inject_arm = 1; inject_vec = 8'h55;
    step();
    virq_set = 0; inject_arm = 0;
    write_ie(1);
    guest_entry = 1; ext_irq = 1; ext_vec = 8'h33;
    step();
    check("R11 injection first", deliver_kind, 1);
    guest_entry = 0;
    step();
    check("R11 external second", deliver_kind, 2);
    check("R11 external vec", deliver_vec, 8'h33);
    ext_irq = 0;
    step();
    check("R11 virtual last", deliver_kind, 3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_ext_exit();
    t_nomask();
    t_window();
    t_prio();
    t_backpressure();
    t_direct();
    t_virt();
    t_inject();
    t_block();
    t_order();
    finish_run();
  end
endmodule